// File: doc/BRIEF.md
# Segment Address Translator with Length Check

This block sits between a processor's logical address bus and physical memory and relocates every access through a table of segment descriptors. The upper bits of a logical address pick a descriptor, and the lower bits give the offset inside that segment. Each descriptor holds a physical base address and a segment length. An access whose offset falls inside the segment is sent on to memory at base plus offset. An access past the end of the segment, or into an empty segment, is refused with a fault.

A host loads descriptors through a simple write port. A bus cycle starts when the logical strobe goes high. The block spends one cycle on the lookup and the comparison. It then raises either the physical strobe, together with the relocated address, or the fault output. Whichever output it raised stays up until the logical strobe is released.

Top module: `seg_xlate`

## Requirements
- R1: After reset, physStrobe and segFault are low, physAddr is 0, and every descriptor has length 0, so any access faults until descriptors are written.
- R2: The segment number is logAddr[23:16] and the segment offset is logAddr[15:0].
- R3: If offset < length, physStrobe is high from the second rising edge after logStrobe is first sampled high, and physAddr is then base + offset. The outputs are still low after the first edge.
- R4: If offset >= length, segFault goes high at that same second edge, and physStrobe stays low for the whole cycle.
- R5: A descriptor with length 0 faults every access made to it.
- R6: A length of 0x10000 (the 17-bit length field) puts every offset from 0x0000 to 0xFFFF in range.
- R7: The sum base + offset wraps modulo 2^24, and no separate overflow is reported.
- R8: physStrobe or segFault stays high while logStrobe is high. Both fall at the first edge that samples logStrobe low. physAddr is 0 whenever physStrobe is low.
- R9: A rising edge with hostWe high writes hostBase and hostLen into descriptor hostIdx. The write replaces the earlier contents of that descriptor and leaves all other descriptors unchanged.
- R10: physStrobe and segFault are never high at the same time.
- R11: logAddr is captured at the edge that starts the cycle. Changing logAddr later in the same cycle has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWe | input | 1 | Descriptor write enable |
| hostIdx | input | 8 | Descriptor index to write |
| hostBase | input | 24 | Physical base to store |
| hostLen | input | 17 | Segment length to store (0 means invalid) |
| logAddr | input | 24 | Logical address |
| logStrobe | input | 1 | Logical address strobe |
| physAddr | output | 24 | Relocated physical address |
| physStrobe | output | 1 | Physical address strobe |
| segFault | output | 1 | Bounds or invalid-segment fault |

## Verification
The bench uses the default parameters: an 8-bit segment number, a 16-bit offset and a 24-bit physical address. With these values a base near the top of the 24-bit space plus a large offset wraps past 2^24. A full 64K-byte length, a one-byte length and an empty segment can all be written. Directed accesses cover the last in-range offset and the first out-of-range offset of a segment. Random accesses land on a small pool of segments whose lengths and bases are rewritten at random, with logAddr sometimes disturbed partway through a cycle.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic capture; // latch the logical address
    logic grant;   // load the relocated address
    logic clear;   // zero the physical address
  } xlCtrl_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XLATE = 2'd1,
    ST_GRANT = 2'd2,
    ST_FAULT = 2'd3
  } xlState_t;
endpackage

// File: rtl/seg_xlate_dp.sv
module seg_xlate_dp
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W  = 8,
  parameter int OFS_W  = 16,
  parameter int ADDR_W = 24,
  localparam int LEN_W = OFS_W + 1,
  localparam int LOG_W = SEG_W + OFS_W,
  localparam int DEPTH = 1 << SEG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWe,
  input  logic [SEG_W-1:0]  hostIdx,
  input  logic [ADDR_W-1:0] hostBase,
  input  logic [LEN_W-1:0]  hostLen,
  input  logic [LOG_W-1:0]  logAddr,
  input  xlCtrl_t           ctrl,
  output logic              inRange,
  output logic [ADDR_W-1:0] physAddr
);
  logic [ADDR_W-1:0] baseTab [DEPTH];
  logic [LEN_W-1:0]  lenTab  [DEPTH];
  logic [SEG_W-1:0]  segReg;
  logic [OFS_W-1:0]  ofsReg;
  logic [ADDR_W-1:0] selBase;
  logic [LEN_W-1:0]  selLen;
  logic [ADDR_W-1:0] relocSum;
  logic [ADDR_W-1:0] physReg;

  // descriptor table: reset clears every length, marking all segments invalid
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        baseTab[i] <= '0;
        lenTab[i]  <= '0;
      end
    end else if (hostWe) begin
      baseTab[hostIdx] <= hostBase;
      lenTab[hostIdx]  <= hostLen;
    end
  end

  // logical address latch
  always_ff @(posedge clk) begin
    if (!rstN) begin
      segReg <= '0;
      ofsReg <= '0;
    end else if (ctrl.capture) begin
      segReg <= logAddr[LOG_W-1:OFS_W];
      ofsReg <= logAddr[OFS_W-1:0];
    end
  end

  assign selBase  = baseTab[segReg];
  assign selLen   = lenTab[segReg];
  assign inRange  = {1'b0, ofsReg} < selLen;
  assign relocSum = selBase + {{(ADDR_W-OFS_W){1'b0}}, ofsReg};

  always_ff @(posedge clk) begin
    if (!rstN)            physReg <= '0;
    else if (ctrl.clear)  physReg <= '0;
    else if (ctrl.grant)  physReg <= relocSum;
  end

  assign physAddr = physReg;

  // R11: latched address only moves on a capture strobe
  a_r11_latch_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.capture |=> $stable(segReg) && $stable(ofsReg));
  // R8: a clear strobe leaves the physical address at zero
  a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.clear |=> physAddr == '0);
endmodule

// File: rtl/seg_xlate_ctrl.sv
module seg_xlate_ctrl
  import seg_xlate_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    logStrobe,
  input  logic    inRange,
  output xlCtrl_t ctrl,
  output logic    physStrobe,
  output logic    segFault
);
  xlState_t state, stateNxt;

  always_comb begin
    stateNxt = state;
    ctrl     = '0;
    unique case (state)
      ST_IDLE: if (logStrobe) begin
        stateNxt     = ST_XLATE;
        ctrl.capture = 1'b1;
      end
      ST_XLATE: begin
        if (inRange) begin
          stateNxt   = ST_GRANT;
          ctrl.grant = 1'b1;
        end else begin
          stateNxt = ST_FAULT;
        end
      end
      ST_GRANT, ST_FAULT: if (!logStrobe) begin
        stateNxt   = ST_IDLE;
        ctrl.clear = 1'b1;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assign physStrobe = (state == ST_GRANT);
  assign segFault   = (state == ST_FAULT);

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(physStrobe && segFault));
  a_r3_grant_in_range: assert property (@(posedge clk) disable iff (!rstN)
    $rose(physStrobe) |-> $past(inRange));
  a_r4_fault_out_of_range: assert property (@(posedge clk) disable iff (!rstN)
    $rose(segFault) |-> !$past(inRange));
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    (physStrobe || segFault) && logStrobe |=> $stable(physStrobe) && $stable(segFault));
  a_r8_release: assert property (@(posedge clk) disable iff (!rstN)
    (physStrobe || segFault) && !logStrobe |=> !physStrobe && !segFault);
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W  = 8,
  parameter int OFS_W  = 16,
  parameter int ADDR_W = 24
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   hostWe,
  input  logic [SEG_W-1:0]       hostIdx,
  input  logic [ADDR_W-1:0]      hostBase,
  input  logic [OFS_W:0]         hostLen,
  input  logic [SEG_W+OFS_W-1:0] logAddr,
  input  logic                   logStrobe,
  output logic [ADDR_W-1:0]      physAddr,
  output logic                   physStrobe,
  output logic                   segFault
);
  xlCtrl_t ctrl;
  logic    inRange;

  seg_xlate_dp #(.SEG_W(SEG_W), .OFS_W(OFS_W), .ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostIdx(hostIdx),
    .hostBase(hostBase), .hostLen(hostLen), .logAddr(logAddr),
    .ctrl(ctrl), .inRange(inRange), .physAddr(physAddr)
  );

  seg_xlate_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .logStrobe(logStrobe), .inRange(inRange),
    .ctrl(ctrl), .physStrobe(physStrobe), .segFault(segFault)
  );

  // R8: no stale address while the strobe is down
  a_r8_addr_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !physStrobe |-> physAddr == '0);
endmodule

// File: tb/seg_xlate_tb_top.sv
module seg_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWe = 1'b0;
  logic [7:0]  hostIdx = '0;
  logic [23:0] hostBase = '0;
  logic [16:0] hostLen = '0;
  logic [23:0] logAddr = '0;
  logic        logStrobe = 1'b0;
  logic [23:0] physAddr;
  logic        physStrobe;
  logic        segFault;

  int vectors = 0;
  int misses = 0;
  bit done = 1'b0;

  logic [23:0] mBase [256];
  logic [16:0] mLen  [256];

  always #10 clk = ~clk;

  seg_xlate dut_i (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostIdx(hostIdx),
    .hostBase(hostBase), .hostLen(hostLen), .logAddr(logAddr),
    .logStrobe(logStrobe), .physAddr(physAddr), .physStrobe(physStrobe),
    .segFault(segFault)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit expHit(input logic [23:0] a);
    return {1'b0, a[15:0]} < mLen[a[23:16]];
  endfunction

  function automatic logic [23:0] expAddr(input logic [23:0] a);
    return mBase[a[23:16]] + {8'h00, a[15:0]};
  endfunction

  task automatic hostWrite(input logic [7:0] idx, input logic [23:0] b, input logic [16:0] l);
    @(negedge clk);
    hostWe = 1'b1; hostIdx = idx; hostBase = b; hostLen = l;
    @(posedge clk);
    @(negedge clk);
    hostWe = 1'b0;
    mBase[idx] = b;
    mLen[idx] = l;
  endtask

  // one bus cycle; optionally disturb logAddr after capture (R11)
  task automatic access(input string req, input logic [23:0] a, input bit tamper);
    bit hit = expHit(a);
    logic [23:0] ea = expAddr(a);
    @(negedge clk);
    logAddr = a; logStrobe = 1'b1;
    @(posedge clk); #5;
    chk({req, " R3 lookup cycle quiet"}, {physStrobe, segFault}, 32'd0);
    if (tamper) begin
      @(negedge clk);
      logAddr = $urandom;
    end
    @(posedge clk); #5;
    chk({req, " R3/R4 strobe"}, physStrobe, hit);
    chk({req, " R4/R5 fault"}, segFault, !hit);
    chk({req, " R2/R7 addr"}, physAddr, hit ? ea : 24'h0);
    chk({req, " R10 exclusive"}, physStrobe & segFault, 32'd0);
    @(posedge clk); #5;
    chk({req, " R8 held"}, {physStrobe, segFault}, {hit, !hit});
    @(negedge clk);
    logStrobe = 1'b0;
    @(posedge clk); #5;
    chk({req, " R8 release"}, {physStrobe, segFault, physAddr}, 32'd0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) begin mBase[i] = '0; mLen[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #5;
    chk("R1 reset outputs", {physStrobe, segFault, physAddr}, 32'd0);
    access("R1 empty table", 24'h123456, 1'b0);
    access("R1 R5 empty seg ff", 24'hFF0000, 1'b0);

    hostWrite(8'h12, 24'h400000, 17'h01000);
    access("R3 first", 24'h120000, 1'b0);
    access("R3 last in range", 24'h120FFF, 1'b0);
    access("R4 first out", 24'h121000, 1'b0);
    access("R4 far out", 24'h12FFFF, 1'b0);

    hostWrite(8'hFF, 24'hFFFF00, 17'h10000);
    access("R6 R7 wrap top", 24'hFFFFFF, 1'b0);
    access("R6 zero ofs", 24'hFF0000, 1'b0);
    chk("R7 model", expAddr(24'hFFFFFF), 24'h00FEFF);

    hostWrite(8'h05, 24'h0ABCDE, 17'h00001);
    access("R3 len1 ofs0", 24'h050000, 1'b0);
    access("R4 len1 ofs1", 24'h050001, 1'b0);

    hostWrite(8'h12, 24'h777000, 17'h00000);
    access("R5 R9 rewritten to empty", 24'h120000, 1'b0);
    access("R9 neighbour intact", 24'h050000, 1'b0);
    access("R11 tamper hit", 24'h050000, 1'b1);
    access("R11 tamper miss", 24'h120010, 1'b1);

    for (int n = 0; n < 300; n++) begin
      logic [7:0] seg = {6'd0, 2'($urandom)} + 8'h40;
      if (($urandom % 3) == 0) begin
        logic [16:0] l;
        case ($urandom % 4)
          0: l = 17'h0;
          1: l = 17'h10000;
          default: l = 17'($urandom % 17'h10001);
        endcase
        hostWrite(seg, 24'($urandom), l);
      end
      access("R3 R4 R9 random", {seg, 16'($urandom)}, ($urandom % 4) == 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule